// File: doc/BRIEF.md
# Interrupt and Trap Entry Controller

This block decides when a simple processor leaves its normal instruction stream to run a handler, and when it comes back. Device lines raise requests that are held in per-line latches; software can raise a trap with a cause code. Both kinds of request are steered through one table of handler addresses, held in registers. On entry the block records the address of the interrupted instruction, masks further requests and drops the privilege bit to monitor. It then tells the fetch stage where to go with a one-cycle redirect pulse carrying the target address.

A return strobe undoes the entry in one clock edge. The saved address is sent out on the redirect port, and the privilege bit and the enable bit take back the values they had before entry. Requests that came in while the handler ran stay latched and are served as soon as the enable bit comes back. Only monitor-mode code may load the handler table. A load attempted from user mode is dropped and turned into a trap.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the redirect output is low, the mode output is 0 (monitor), the enable output is 1 and no device request is latched.
- R2: A pulse on device line i is latched at a clock edge. At the next edge, if enabled, it is accepted. During the cycle after that edge the redirect output is high for one cycle and the target equals table entry i.
- R3: When several device lines are latched, the lowest-numbered one is taken first. The others stay latched and are taken later in ascending order.
- R4: A trap request with cause c is accepted at the edge where it is sampled high, and the target is table entry NUM_IRQ+c. A trap wins over latched device requests in the same cycle, and those requests stay latched.
- R5: On acceptance the enable output goes to 0 and the mode output goes to 0. The current PC value sampled at that edge is stored as the return address.
- R6: Device pulses that arrive while the enable output is 0 cause no redirect and are not lost. They are taken after the return.
- R7: A table load at index k (0..NUM_IRQ-1 for device lines, NUM_IRQ+c for trap cause c) is performed only in monitor mode. In user mode the table is left unchanged and a trap with cause VIOL_CAUSE (default 7, entry NUM_IRQ+7) is taken instead.
- R8: A return strobe while the enable output is 0 restores the mode and enable bits at that edge. In the next cycle it gives a one-cycle redirect to the stored return address. A return strobe while the enable output is 1 is ignored.
- R9: A user-entry strobe sets the mode output to 1 (user). An acceptance in the same cycle takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | NUM_IRQ | Device request pulses, bit i for line i |
| trapReq | input | 1 | Software trap request |
| trapCause | input | CAUSE_W | Cause code of the trap |
| curPc | input | PC_W | Address of the instruction now executing |
| retStrobe | input | 1 | Return from handler |
| userGo | input | 1 | Switch the privilege bit to user |
| vecWrEn | input | 1 | Handler table load strobe |
| vecWrIdx | input | IDX_W | Handler table index to load |
| vecWrData | input | PC_W | Handler address to load |
| redirect | output | 1 | One-cycle redirect pulse |
| redirectPc | output | PC_W | Target address, valid with redirect |
| userMode | output | 1 | Privilege bit, 1 = user, 0 = monitor |
| intEnable | output | 1 | 1 when requests may be accepted |

## Verification
The assertions assume that trap requests are raised only while the enable output is 1, and never in the same cycle as a table load. A trap that arrives in a handler is otherwise dropped, and a trap that arrives with a load is overridden by the violation cause. The stimulus raises traps only after a return has re-enabled the block, and it keeps table loads apart from trap requests. Device pulses and return strobes are driven freely, including while masked and while already enabled, because the block must handle both cases.

// File: rtl/tec_pkg.sv
package tec_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic entry;  // take a handler this edge
    logic ret;    // leave the handler this edge
    logic vecWr;  // load one handler table entry
  } tecStrobe_t;
endpackage

// File: rtl/tec_ctrl.sv
module tec_ctrl
  import tec_pkg::*;
#(
  parameter int NUM_IRQ    = 4,
  parameter int CAUSE_W    = 3,
  parameter int VIOL_CAUSE = 7,
  localparam int NUM_VEC   = NUM_IRQ + (1 << CAUSE_W),
  localparam int IDX_W     = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               trapReq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic               retStrobe,
  input  logic               userGo,
  input  logic               vecWrEn,
  input  logic [IDX_W-1:0]   vecWrIdx,
  output tecStrobe_t         st,
  output logic [IDX_W-1:0]   selIdx,
  output logic               userMode,
  output logic               intEnable
);
  logic [NUM_IRQ-1:0] pendQ, lineOneHot;
  logic [IDX_W-1:0]   lineIdx;
  logic modeQ, ieQ, savedModeQ, savedIeQ;
  logic violation, anyPend, takeLine;

  // Lowest-numbered latched line wins
  always_comb begin
    lineIdx    = '0;
    lineOneHot = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pendQ[i]) begin
        lineIdx    = IDX_W'(i);
        lineOneHot = NUM_IRQ'(1) << i;
      end
    end
  end

  assign violation = vecWrEn & modeQ;
  assign anyPend   = |pendQ;
  assign st.entry  = ieQ & (violation | trapReq | anyPend);
  assign st.ret    = retStrobe & ~ieQ;
  assign st.vecWr  = vecWrEn & ~modeQ & (int'(vecWrIdx) < NUM_VEC);
  assign takeLine  = st.entry & ~violation & ~trapReq;

  always_comb begin
    if (violation)    selIdx = IDX_W'(NUM_IRQ + VIOL_CAUSE);
    else if (trapReq) selIdx = IDX_W'(NUM_IRQ + int'(trapCause));
    else              selIdx = lineIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= '0;
      modeQ      <= 1'b0;
      ieQ        <= 1'b1;
      savedModeQ <= 1'b0;
      savedIeQ   <= 1'b1;
    end else begin
      pendQ <= (pendQ & ~(takeLine ? lineOneHot : '0)) | irqReq;
      if (st.entry) begin
        savedModeQ <= modeQ;
        savedIeQ   <= ieQ;
        modeQ      <= 1'b0;
        ieQ        <= 1'b0;
      end else if (st.ret) begin
        modeQ <= savedModeQ;
        ieQ   <= savedIeQ;
      end else if (userGo) begin
        modeQ <= 1'b1;
      end
    end
  end

  assign userMode  = modeQ;
  assign intEnable = ieQ;

  AST_ENTRY_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    st.entry |=> (!modeQ && !ieQ)); // R5
  AST_MASKED_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    !ieQ |=> ((pendQ & $past(pendQ)) == $past(pendQ))); // R6
  AST_USER_WR_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (vecWrEn && modeQ) |-> (st.entry && !st.vecWr)); // R7
  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rstN)
    st.ret |=> (ieQ == $past(savedIeQ) && modeQ == $past(savedModeQ))); // R8
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    !(st.entry && st.ret)); // R8
endmodule

// File: rtl/tec_datapath.sv
module tec_datapath
  import tec_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int CAUSE_W  = 3,
  parameter int PC_W     = 16,
  localparam int NUM_VEC = NUM_IRQ + (1 << CAUSE_W),
  localparam int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tecStrobe_t       st,
  input  logic [IDX_W-1:0] selIdx,
  input  logic [IDX_W-1:0] vecWrIdx,
  input  logic [PC_W-1:0]  vecWrData,
  input  logic [PC_W-1:0]  curPc,
  output logic             redirect,
  output logic [PC_W-1:0]  redirectPc
);
  logic [PC_W-1:0] vecQ [NUM_VEC];
  logic [PC_W-1:0] savedPcQ;
  logic [PC_W-1:0] target;

  // Handler address table, one register per entry
  for (genvar g = 0; g < NUM_VEC; g++) begin : gVec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     vecQ[g] <= '0;
      else if (st.vecWr && int'(vecWrIdx) == g)      vecQ[g] <= vecWrData;
    end
  end

  always_comb begin
    target = '0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (int'(selIdx) == k) target = vecQ[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPcQ   <= '0;
      redirect   <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirect <= st.entry | st.ret;
      if (st.entry) begin
        savedPcQ   <= curPc;
        redirectPc <= target;
      end else if (st.ret) begin
        redirectPc <= savedPcQ;
      end
    end
  end

  AST_SAVED_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !st.entry |=> $stable(savedPcQ)); // R5
  AST_REDIRECT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> $past(st.entry || st.ret)); // R2
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    st.ret |=> (redirect && redirectPc == $past(savedPcQ))); // R8
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import tec_pkg::*;
#(
  parameter int NUM_IRQ    = 4,
  parameter int CAUSE_W    = 3,
  parameter int PC_W       = 16,
  parameter int VIOL_CAUSE = 7,
  localparam int NUM_VEC   = NUM_IRQ + (1 << CAUSE_W),
  localparam int IDX_W     = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               trapReq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [PC_W-1:0]    curPc,
  input  logic               retStrobe,
  input  logic               userGo,
  input  logic               vecWrEn,
  input  logic [IDX_W-1:0]   vecWrIdx,
  input  logic [PC_W-1:0]    vecWrData,
  output logic               redirect,
  output logic [PC_W-1:0]    redirectPc,
  output logic               userMode,
  output logic               intEnable
);
  tecStrobe_t       st;
  logic [IDX_W-1:0] selIdx;

  tec_ctrl #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W), .VIOL_CAUSE(VIOL_CAUSE)) u_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .trapReq(trapReq),
    .trapCause(trapCause), .retStrobe(retStrobe), .userGo(userGo),
    .vecWrEn(vecWrEn), .vecWrIdx(vecWrIdx), .st(st), .selIdx(selIdx),
    .userMode(userMode), .intEnable(intEnable)
  );

  tec_datapath #(.NUM_IRQ(NUM_IRQ), .CAUSE_W(CAUSE_W), .PC_W(PC_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .selIdx(selIdx), .vecWrIdx(vecWrIdx),
    .vecWrData(vecWrData), .curPc(curPc), .redirect(redirect),
    .redirectPc(redirectPc)
  );
endmodule

// File: tb/irq_entry_ctrl_bench.sv
module irq_entry_ctrl_bench;
  localparam int NUM_IRQ = 4;
  localparam int CAUSE_W = 3;
  localparam int PC_W    = 16;
  localparam int NUM_VEC = NUM_IRQ + (1 << CAUSE_W);
  localparam int IDX_W   = $clog2(NUM_VEC);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IRQ-1:0] irqReq = '0;
  logic trapReq = 1'b0;
  logic [CAUSE_W-1:0] trapCause = '0;
  logic [PC_W-1:0] curPc = '0;
  logic retStrobe = 1'b0, userGo = 1'b0, vecWrEn = 1'b0;
  logic [IDX_W-1:0] vecWrIdx = '0;
  logic [PC_W-1:0] vecWrData = '0;
  logic redirect, userMode, intEnable;
  logic [PC_W-1:0] redirectPc;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [PC_W-1:0] expQ [$];
  string tagQ [$];

  always #2 clk = ~clk;

  irq_entry_ctrl u_irq_entry_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .trapReq(trapReq),
    .trapCause(trapCause), .curPc(curPc), .retStrobe(retStrobe),
    .userGo(userGo), .vecWrEn(vecWrEn), .vecWrIdx(vecWrIdx),
    .vecWrData(vecWrData), .redirect(redirect), .redirectPc(redirectPc),
    .userMode(userMode), .intEnable(intEnable)
  );

  function automatic logic [PC_W-1:0] vecVal(int k);
    return PC_W'(16'h1000 + k * 16'h0040);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_redirect(logic [PC_W-1:0] pc, string tag);
    expQ.push_back(pc);
    tagQ.push_back(tag);
  endtask

  task automatic check(logic [PC_W-1:0] act, logic [PC_W-1:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulseIrq(int line);
    irqReq[line] = 1'b1;
    tick();
    irqReq = '0;
  endtask

  task automatic pulseRet();
    retStrobe = 1'b1;
    tick();
    retStrobe = 1'b0;
  endtask

  // Monitor: pops one expected target per redirect pulse
  always @(negedge clk) begin
    if (rstN && redirect) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R2/R8 unexpected redirect actual=%h expected=none", redirectPc);
      end else begin
        logic [PC_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (redirectPc !== e) begin
          bad++;
          $display("FAIL %s redirect actual=%h expected=%h", t, redirectPc, e);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check(PC_W'(redirect), 0, "R1 redirect");
    check(PC_W'(userMode), 0, "R1 mode");
    check(PC_W'(intEnable), 1, "R1 enable");
    tick();
    check(PC_W'(redirect), 0, "R1 no latched request");

    // R7 table load in monitor mode
    for (int k = 0; k < NUM_VEC; k++) begin
      vecWrEn = 1'b1; vecWrIdx = IDX_W'(k); vecWrData = vecVal(k);
      tick();
    end
    vecWrEn = 1'b0;

    // R2 device line 2
    curPc = 16'h0200;
    expect_redirect(vecVal(2), "R2 line2");
    pulseIrq(2);
    tick();
    check(PC_W'(intEnable), 0, "R5 enable cleared");
    check(PC_W'(userMode), 0, "R5 monitor");

    // R6 requests while masked are held
    pulseIrq(3);
    pulseIrq(1);
    tick(); tick(); tick();
    check(PC_W'(intEnable), 0, "R6 still masked");

    // R8 return then R3 lowest line first
    curPc = 16'h0300;
    expect_redirect(16'h0200, "R8 return pc");
    expect_redirect(vecVal(1), "R3 line1 first");
    pulseRet();
    tick();
    check(PC_W'(intEnable), 0, "R3 entry after return");
    curPc = 16'h0340;
    expect_redirect(16'h0300, "R5 saved pc line1");
    expect_redirect(vecVal(3), "R6 line3 later");
    pulseRet();
    tick(); tick();
    curPc = 16'h0500;
    expect_redirect(16'h0340, "R5 saved pc line3");
    pulseRet();
    tick();
    check(PC_W'(intEnable), 1, "R8 enable restored");
    check(PC_W'(userMode), 0, "R8 mode restored monitor");

    // R9 enter user mode
    userGo = 1'b1; tick(); userGo = 1'b0;
    check(PC_W'(userMode), 1, "R9 user mode");

    // R4 trap wins over a latched line
    curPc = 16'h0600;
    expect_redirect(vecVal(NUM_IRQ + 2), "R4 trap cause2");
    irqReq[0] = 1'b1; tick(); irqReq = '0;
    trapReq = 1'b1; trapCause = 3'd2; tick(); trapReq = 1'b0;
    check(PC_W'(userMode), 0, "R5 trap forces monitor");
    check(PC_W'(intEnable), 0, "R5 trap masks");
    expect_redirect(16'h0600, "R8 return from trap");
    expect_redirect(vecVal(0), "R4 held line0 taken");
    pulseRet();
    check(PC_W'(userMode), 1, "R8 user mode restored");
    tick();
    check(PC_W'(userMode), 0, "R5 line0 monitor");
    expect_redirect(16'h0600, "R8 return from line0");
    pulseRet();
    tick();
    check(PC_W'(userMode), 1, "R8 user after line0");
    check(PC_W'(intEnable), 1, "R8 enable after line0");

    // R7 user-mode load is dropped and traps
    curPc = 16'h0700;
    expect_redirect(vecVal(NUM_IRQ + 7), "R7 violation trap");
    vecWrEn = 1'b1; vecWrIdx = '0; vecWrData = 16'hDEAD;
    tick();
    vecWrEn = 1'b0;
    check(PC_W'(userMode), 0, "R7 violation monitor");
    expect_redirect(16'h0700, "R7 return");
    pulseRet();
    tick();
    expect_redirect(vecVal(0), "R7 entry 0 unchanged");
    pulseIrq(0);
    tick();
    expect_redirect(16'h0700, "R7 return 2");
    pulseRet();
    tick();

    // R8 return while enabled is ignored
    pulseRet();
    tick(); tick();
    check(PC_W'(intEnable), 1, "R8 ignored return enable");
    check(PC_W'(userMode), 1, "R8 ignored return mode");

    tick(); tick();
    check(PC_W'(expQ.size()), 0, "R2 all redirects seen");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule